// File: doc/BRIEF.md
# Looping Sideband Command Sequencer

This block drives a narrow sideband bus that shares its clock with a wider main data bus but runs its own cycles. During initialization a host fills a small command table and sets how many entries are live. When `run` goes high, the sequencer works through those entries in order. After the last live entry it goes back to entry 0 and repeats, with no further host action, until `run` is dropped.

Every command uses exactly two bus cycles and addresses one attached device. There are four command kinds. A status sample reads a device's FIFO status into a local status register. A flow-control send pushes a one-byte message to a MAC device. A peer read fetches one byte from a peer device. A peer write forwards a locally held status byte to a peer. The status registers, the last peer-read byte and the last flow-control message appear on output ports.

Top module: `sbq_sequencer`

## Requirements
- R1: Reset state.
  - The sequencer is stopped, `busy` is 0 and `ld_err` is 0.
  - The bus is idle: `sb_sel` is 0, `sb_rd` is 0, `sb_wr` is 0 and `sb_dout` is 0.
  - Every status register, `peer_rd_data` and `fc_msg` is 0.
  - Every table entry is zero and the live-entry count is 1.
- R2: Table loading while stopped.
  - When `ld_en` is high and the sequencer is stopped, `ld_addr` 0 to 11 writes `ld_data` into that table entry.
  - `ld_addr` 15 writes `ld_data[3:0]` into the live-entry count.
  - `ld_addr` 12 to 14 change nothing.
- R3: A load presented while `busy` is 1 is discarded and sets `ld_err`. `ld_err` then stays 1 until reset.
- R4: The live-entry count is clamped when written. A written 0 becomes 1, and a written value above 12 becomes 12.
- R5: Command word layout and bus cycles.
  - `[12:11]` is the opcode: 0 = status sample, 1 = flow-control send, 2 = peer read, 3 = peer write.
  - `[10:8]` is the device code. `[7:0]` is the argument.
  - Each command takes two cycles, a select cycle followed by a strobe cycle.
  - `sb_sel` carries the device code in both cycles.
  - `sb_rd` and `sb_wr` are never high together.
- R6: Status sample.
  - `sb_dout` is 0 in both cycles and `sb_rd` is high in the strobe cycle only.
  - `sb_din` is captured at the end of the strobe cycle into status register `arg[2:0]`. Register k sits on `stat_flat[8k+7:8k]`.
- R7: Flow-control send.
  - `sb_dout` equals the argument in both cycles and `sb_wr` is high in the strobe cycle only.
  - `fc_msg` takes the argument at the end of the strobe cycle.
- R8: Peer read.
  - `sb_dout` carries the argument, used as the remote register index, in both cycles.
  - `sb_rd` is high in the strobe cycle only.
  - `sb_din` is captured into `peer_rd_data` at the end of the strobe cycle.
- R9: Peer write. `sb_dout` carries status register `arg[2:0]` in both cycles, and `sb_wr` is high in the strobe cycle only.
- R10: Starting and looping.
  - `run` high while stopped starts entry 0, whose select cycle appears in the next cycle.
  - Commands follow each other with no gap.
  - After the strobe cycle of entry count-1, entry 0 follows.
- R11: Stopping.
  - `run` is examined only at the end of a strobe cycle. If it is low there, the sequencer is stopped in the next cycle.
  - A command that has begun always completes.
- R12: While stopped, the bus stays idle with all bus outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Level request to execute the table loop |
| ld_en | input | 1 | Table/count load strobe |
| ld_addr | input | 4 | Load target: entry 0-11, or 15 for the count |
| ld_data | input | 13 | Command word, or count in bits [3:0] |
| sb_din | input | 8 | Sideband data from devices |
| sb_dout | output | 8 | Sideband data to devices |
| sb_sel | output | 3 | Device code control lines |
| sb_rd | output | 1 | Read strobe control line |
| sb_wr | output | 1 | Write strobe control line |
| busy | output | 1 | Sequencer is looping |
| ld_err | output | 1 | Sticky flag: load attempted while busy |
| stat_flat | output | 64 | Eight 8-bit status registers, register k at [8k+7:8k] |
| peer_rd_data | output | 8 | Last byte fetched by a peer read |
| fc_msg | output | 8 | Last flow-control message sent |

## Verification
A slot pointer or phase bit that drifts shows up on `sb_sel`, `sb_dout` or a strobe within the same cycle, because every bus output is decoded from the current entry and phase. A wrong wrap point appears one command later, as an unexpected device code where entry 0 should be. A status byte written to the wrong register shows up on `stat_flat` at once. It also corrupts the payload of any later peer write that forwards that register. A load that slips through while looping stays invisible until that entry next runs, which is at most one full loop later, and `ld_err` exposes it one cycle after the attempt.

// File: rtl/sbq_pkg.sv
package sbq_pkg;

    localparam int DATA_W = 8;
    localparam int DEV_W  = 3;

    typedef enum logic [1:0] {
        OP_SAMPLE  = 2'd0,
        OP_FLOW    = 2'd1,
        OP_PEER_RD = 2'd2,
        OP_PEER_WR = 2'd3
    } sbq_op_e;

    typedef struct packed {
        sbq_op_e            op;
        logic [DEV_W-1:0]   dev;
        logic [DATA_W-1:0]  arg;
    } sbq_cmd_t;

    localparam int CMD_W = $bits(sbq_cmd_t);

    typedef enum logic {
        PH_SEL    = 1'b0,
        PH_STROBE = 1'b1
    } sbq_phase_e;

    typedef struct packed {
        logic [DEV_W-1:0]  sel;
        logic              rd;
        logic              wr;
        logic [DATA_W-1:0] dout;
    } sbq_bus_t;

    // Opcodes whose strobe cycle reads the data lines
    function automatic logic op_reads(input sbq_op_e op);
        return (op == OP_SAMPLE) || (op == OP_PEER_RD);
    endfunction

endpackage

// File: rtl/sbq_cmd_table.sv
module sbq_cmd_table
    import sbq_pkg::*;
#(
    parameter int NUM_SLOTS = 12,
    parameter int AW        = $clog2(NUM_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic             ld_en,
    input  logic [AW-1:0]    ld_addr,
    input  logic [CMD_W-1:0] ld_data,
    input  logic [AW-1:0]    rd_slot,
    output sbq_cmd_t         cur_cmd,
    output logic [AW-1:0]    count,
    output logic             ld_err
);

    localparam logic [AW-1:0] CNT_ADDR = '1;
    localparam logic [AW-1:0] MAX_CNT  = AW'(NUM_SLOTS);

    logic [CMD_W-1:0] mem [NUM_SLOTS];
    logic [AW-1:0]    cnt_next;

    always_comb begin
        cnt_next = ld_data[AW-1:0];
        if (cnt_next == '0)
            cnt_next = AW'(1);
        else if (cnt_next > MAX_CNT)
            cnt_next = MAX_CNT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SLOTS; i++)
                mem[i] <= '0;
            count  <= AW'(1);
            ld_err <= 1'b0;
        end else if (ld_en) begin
            if (busy)
                ld_err <= 1'b1;
            else if (ld_addr < MAX_CNT)
                mem[ld_addr] <= ld_data;
            else if (ld_addr == CNT_ADDR)
                count <= cnt_next;
        end
    end

    always_comb begin
        if (rd_slot < MAX_CNT)
            cur_cmd = sbq_cmd_t'(mem[rd_slot]);
        else
            cur_cmd = '0;
    end

    AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (busy && ld_en) |=> ld_err) else $error("load while busy not flagged"); // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ld_err |=> ld_err) else $error("load error flag cleared"); // R3

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (count != '0) && (count <= MAX_CNT)) else $error("count out of range"); // R4

endmodule

// File: rtl/sbq_ctrl.sv
module sbq_ctrl
    import sbq_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [AW-1:0] count,
    output logic          busy,
    output logic [AW-1:0] slot,
    output sbq_phase_e    phase
);

    logic last_slot;
    assign last_slot = (slot == count - AW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            slot  <= '0;
            phase <= PH_SEL;
        end else if (!busy) begin
            if (run) begin
                busy  <= 1'b1;
                slot  <= '0;
                phase <= PH_SEL;
            end
        end else if (phase == PH_SEL) begin
            phase <= PH_STROBE;
        end else begin
            phase <= PH_SEL;
            if (!run) begin
                busy <= 1'b0;
                slot <= '0;
            end else if (last_slot) begin
                slot <= '0;
            end else begin
                slot <= slot + AW'(1);
            end
        end
    end

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (slot < count)) else $error("slot beyond count"); // R10

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (busy && phase == PH_STROBE && run && last_slot) |=> (busy && slot == '0))
        else $error("no wrap to entry 0"); // R10

    AST_STOP_AT_END: assert property (@(posedge clk) disable iff (rst)
        (busy && phase == PH_STROBE && !run) |=> !busy) else $error("did not stop"); // R11

    AST_NO_ABORT: assert property (@(posedge clk) disable iff (rst)
        (busy && phase == PH_SEL) |=> (busy && phase == PH_STROBE && $stable(slot)))
        else $error("command aborted"); // R11

endmodule

// File: rtl/sbq_status.sv
module sbq_status
    import sbq_pkg::*;
#(
    parameter int NUM_STAT = 8,
    parameter int IDX_W    = $clog2(NUM_STAT)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cap_en,
    input  sbq_cmd_t                   cur_cmd,
    input  logic [DATA_W-1:0]          sb_din,
    output logic [DATA_W-1:0]          stat_pick,
    output logic [NUM_STAT*DATA_W-1:0] stat_flat,
    output logic [DATA_W-1:0]          peer_rd_data,
    output logic [DATA_W-1:0]          fc_msg
);

    logic [DATA_W-1:0] stat_q [NUM_STAT];
    logic [IDX_W-1:0]  idx;

    assign idx       = cur_cmd.arg[IDX_W-1:0];
    assign stat_pick = stat_q[idx];

    for (genvar g = 0; g < NUM_STAT; g++) begin : g_stat
        always_ff @(posedge clk) begin
            if (rst)
                stat_q[g] <= '0;
            else if (cap_en && cur_cmd.op == OP_SAMPLE && idx == IDX_W'(g))
                stat_q[g] <= sb_din;
        end
        assign stat_flat[g*DATA_W +: DATA_W] = stat_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            peer_rd_data <= '0;
            fc_msg       <= '0;
        end else if (cap_en) begin
            if (cur_cmd.op == OP_PEER_RD)
                peer_rd_data <= sb_din;
            if (cur_cmd.op == OP_FLOW)
                fc_msg <= cur_cmd.arg;
        end
    end

    AST_SAMPLE_STORED: assert property (@(posedge clk) disable iff (rst)
        (cap_en && cur_cmd.op == OP_SAMPLE) |=> (stat_flat[$past(idx)*DATA_W +: DATA_W] == $past(sb_din)))
        else $error("sampled status lost"); // R6

    AST_PEER_STORED: assert property (@(posedge clk) disable iff (rst)
        (cap_en && cur_cmd.op == OP_PEER_RD) |=> (peer_rd_data == $past(sb_din)))
        else $error("peer read byte lost"); // R8

endmodule

// File: rtl/sbq_sequencer.sv
module sbq_sequencer
    import sbq_pkg::*;
#(
    parameter int NUM_SLOTS = 12,
    parameter int NUM_STAT  = 8,
    parameter int AW        = $clog2(NUM_SLOTS + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       run,
    input  logic                       ld_en,
    input  logic [AW-1:0]              ld_addr,
    input  logic [CMD_W-1:0]           ld_data,
    input  logic [DATA_W-1:0]          sb_din,
    output logic [DATA_W-1:0]          sb_dout,
    output logic [DEV_W-1:0]           sb_sel,
    output logic                       sb_rd,
    output logic                       sb_wr,
    output logic                       busy,
    output logic                       ld_err,
    output logic [NUM_STAT*DATA_W-1:0] stat_flat,
    output logic [DATA_W-1:0]          peer_rd_data,
    output logic [DATA_W-1:0]          fc_msg
);

    sbq_cmd_t          cur_cmd;
    logic [AW-1:0]     count;
    logic [AW-1:0]     slot;
    sbq_phase_e        phase;
    logic [DATA_W-1:0] stat_pick;
    logic              strobe;
    sbq_bus_t          bus;

    assign strobe = busy && (phase == PH_STROBE);

    sbq_cmd_table #(.NUM_SLOTS(NUM_SLOTS), .AW(AW)) i_table (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .rd_slot (slot),
        .cur_cmd (cur_cmd),
        .count   (count),
        .ld_err  (ld_err)
    );

    sbq_ctrl #(.AW(AW)) i_ctrl (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .count (count),
        .busy  (busy),
        .slot  (slot),
        .phase (phase)
    );

    sbq_status #(.NUM_STAT(NUM_STAT)) i_status (
        .clk          (clk),
        .rst          (rst),
        .cap_en       (strobe),
        .cur_cmd      (cur_cmd),
        .sb_din       (sb_din),
        .stat_pick    (stat_pick),
        .stat_flat    (stat_flat),
        .peer_rd_data (peer_rd_data),
        .fc_msg       (fc_msg)
    );

    always_comb begin
        bus = '0;
        if (busy) begin
            bus.sel = cur_cmd.dev;
            unique case (cur_cmd.op)
                OP_SAMPLE:  bus.dout = '0;
                OP_FLOW:    bus.dout = cur_cmd.arg;
                OP_PEER_RD: bus.dout = cur_cmd.arg;
                OP_PEER_WR: bus.dout = stat_pick;
                default:    bus.dout = '0;
            endcase
            bus.rd = strobe && op_reads(cur_cmd.op);
            bus.wr = strobe && !op_reads(cur_cmd.op);
        end
    end

    assign sb_sel  = bus.sel;
    assign sb_rd   = bus.rd;
    assign sb_wr   = bus.wr;
    assign sb_dout = bus.dout;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sb_rd, sb_wr})) else $error("read and write strobes together"); // R5

    AST_WR_HELD: assert property (@(posedge clk) disable iff (rst)
        sb_wr |-> (!$past(sb_wr) && $stable(sb_dout) && $stable(sb_sel)))
        else $error("write payload not held two cycles"); // R7

    AST_RD_SECOND: assert property (@(posedge clk) disable iff (rst)
        sb_rd |-> (!$past(sb_rd) && $stable(sb_sel)))
        else $error("read strobe outside strobe cycle"); // R6

    AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!sb_rd && !sb_wr && sb_sel == '0))
        else $error("bus active after stop"); // R12

endmodule

// File: tb/test_sbq_sequencer.sv
module test_sbq_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_addr = '0;
    logic [12:0] ld_data = '0;
    logic [7:0]  sb_din;
    logic [7:0]  sb_dout;
    logic [2:0]  sb_sel;
    logic        sb_rd, sb_wr, busy, ld_err;
    logic [63:0] stat_flat;
    logic [7:0]  peer_rd_data, fc_msg;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [7:0] tick = 8'd0;

    always #2.5 clk = ~clk;

    // simple device: answers depend on the select code and a running tick
    assign sb_din = tick ^ {sb_sel, 5'b10101};

    sbq_sequencer i_sbq_sequencer (
        .clk(clk), .rst(rst), .run(run), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .sb_din(sb_din), .sb_dout(sb_dout), .sb_sel(sb_sel),
        .sb_rd(sb_rd), .sb_wr(sb_wr), .busy(busy), .ld_err(ld_err),
        .stat_flat(stat_flat), .peer_rd_data(peer_rd_data), .fc_msg(fc_msg)
    );

    // ---------------- reference model ----------------
    logic [12:0] m_tbl [16];
    logic [7:0]  m_stat [8];
    int          m_cnt, m_slot, m_phase;
    logic        m_busy, m_err;
    logic [7:0]  m_peer, m_fc;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) m_tbl[i] = '0;
            for (int i = 0; i < 8; i++)  m_stat[i] = '0;
            m_cnt = 1; m_slot = 0; m_phase = 0;
            m_busy = 1'b0; m_err = 1'b0; m_peer = '0; m_fc = '0;
        end else begin
            if (m_busy && m_phase == 1) begin
                case (m_tbl[m_slot][12:11])
                    2'd0: m_stat[m_tbl[m_slot][2:0]] = sb_din;
                    2'd1: m_fc = m_tbl[m_slot][7:0];
                    2'd2: m_peer = sb_din;
                    default: ;
                endcase
            end
            if (ld_en) begin
                if (m_busy) m_err = 1'b1;
                else if (ld_addr < 12) m_tbl[ld_addr] = ld_data;
                else if (ld_addr == 15) begin
                    m_cnt = int'(ld_data[3:0]);
                    if (m_cnt == 0) m_cnt = 1;
                    if (m_cnt > 12) m_cnt = 12;
                end
            end
            if (!m_busy) begin
                if (run) begin m_busy = 1'b1; m_slot = 0; m_phase = 0; end
            end else if (m_phase == 0) begin
                m_phase = 1;
            end else begin
                m_phase = 0;
                if (!run) begin m_busy = 1'b0; m_slot = 0; end
                else m_slot = (m_slot == m_cnt - 1) ? 0 : m_slot + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        tick <= tick + 8'd7;
        if (!rst) begin
            logic [12:0] c;
            string tag;
            int e_sel, e_rd, e_wr, e_dout;
            c = m_tbl[m_slot];
            e_sel = 0; e_rd = 0; e_wr = 0; e_dout = 0; tag = "R12";
            if (m_busy) begin
                e_sel = int'(c[10:8]);
                case (c[12:11])
                    2'd0: begin tag = "R6"; e_rd = m_phase; end
                    2'd1: begin tag = "R7"; e_dout = int'(c[7:0]); e_wr = m_phase; end
                    2'd2: begin tag = "R8"; e_dout = int'(c[7:0]); e_rd = m_phase; end
                    default: begin tag = "R9"; e_dout = int'(m_stat[c[2:0]]); e_wr = m_phase; end
                endcase
            end
            chk("R5", "sb_sel", int'(sb_sel), e_sel);
            chk(tag, "sb_rd", int'(sb_rd), e_rd);
            chk(tag, "sb_wr", int'(sb_wr), e_wr);
            chk(tag, "sb_dout", int'(sb_dout), e_dout);
            chk("R10", "busy", int'(busy), int'(m_busy));
            chk("R3", "ld_err", int'(ld_err), int'(m_err));
            for (int k = 0; k < 8; k++)
                chk("R6", "stat", int'(stat_flat[8*k +: 8]), int'(m_stat[k]));
            chk("R8", "peer_rd_data", int'(peer_rd_data), int'(m_peer));
            chk("R7", "fc_msg", int'(fc_msg), int'(m_fc));
        end
    end

    function automatic logic [12:0] mk(input int op, input int dev, input int arg);
        return {op[1:0], dev[2:0], arg[7:0]};
    endfunction

    task automatic load(input int addr, input logic [12:0] data);
        ld_addr = addr[3:0]; ld_data = data; ld_en = 1'b1;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles, expected under 20000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "ld_err", int'(ld_err), 0);
        chk("R1", "bus", int'({sb_sel, sb_rd, sb_wr, sb_dout}), 0);
        chk("R1", "stat", int'(stat_flat != '0), 0);
        chk("R1", "fc_msg", int'(fc_msg), 0);

        // R1: zero table with count 1 loops on entry 0 (sample, device 0, index 0)
        run = 1'b1; repeat (6) @(negedge clk);
        run = 1'b0; repeat (4) @(negedge clk);

        // R2: load table entries and count; address 13 must be ignored
        load(0, mk(0, 2, 3));
        load(1, mk(1, 5, 8'hA5));
        load(2, mk(3, 1, 3));
        load(3, mk(2, 7, 8'h42));
        load(4, mk(0, 6, 0));
        load(13, mk(1, 4, 8'hEE));
        load(15, 13'd5);

        run = 1'b1;
        @(negedge clk);
        chk("R10", "start select", int'(sb_sel), 2);
        @(negedge clk);
        @(negedge clk);
        chk("R2", "entry1 payload", int'(sb_dout), 8'hA5);
        repeat (24) @(negedge clk);
        run = 1'b0;          // dropped during a select cycle: R11
        @(negedge clk);
        chk("R11", "no abort", int'(busy), 1);
        repeat (5) @(negedge clk);

        // R3: load while looping is discarded and flagged
        run = 1'b1; repeat (3) @(negedge clk);
        load(0, mk(1, 3, 8'h99));
        chk("R3", "ld_err set", int'(ld_err), 1);
        repeat (12) @(negedge clk);
        run = 1'b0; repeat (4) @(negedge clk);

        // R4: count 0 clamps to 1, entry 0 repeats
        load(15, 13'd0);
        run = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4", "count 0 -> entry 0 again", int'(sb_sel), 2);
        repeat (5) @(negedge clk);
        run = 1'b0; repeat (4) @(negedge clk);

        // R4: fill all twelve entries, count 14 clamps to 12
        for (int i = 0; i < 12; i++)
            load(i, mk(i % 4, (i * 3) % 8, (i * 29 + 5) % 256));
        load(15, 13'd14);
        run = 1'b1; repeat (60) @(negedge clk);
        run = 1'b0; repeat (4) @(negedge clk);

        // R11: one-cycle run pulse runs exactly one command
        run = 1'b1; @(negedge clk);
        run = 1'b0; repeat (5) @(negedge clk);

        finish_run();
    end

endmodule